// File: doc/BRIEF.md
# Frame Descriptor Check and Sequencer

This block sits between the register file of a display controller and its frame-fetch engine. Once per frame-start tick, while the controller is running, it looks at the first palette word of the current frame buffer and works out the pixel depth, the colour format, and how far past the buffer base the pixel data begins. It then checks that the whole picture fits inside the buffer. If it fits, the block hands the fetch engine a registered frame descriptor and raises the condition and interrupt lines on the DMA side. If it does not fit, the block flags a sync error and stops the controller.

The block also covers the enable and disable handshake. On an enable it checks the buffer addresses, which arrive as validity flags from the bus fabric, and it asks for a palette load. In dual-buffer mode it alternates between two frame buffers. The actual memory reads and the drawing of pixels are done elsewhere.

Top module: `lcdseq_frame`

## Requirements
- R1: The depth code is bits 14:12 of `pal_word0`. On a completed frame, `bpp` reports 2 for code 1, 4 for code 2, 8 for code 3, and 16 for codes 4 to 7.
- R2: A tick whose depth code is 0 is skipped. There is no `done`, no `cond_set`, no `dma_irq`, no change to `sync_err`, and `active` stays 1.
- R3: `fmt16` is 1 only when the frame is 16 bpp and `tft` is 1. Otherwise it is 0, which means 12-bit colour when the frame is 16 bpp.
- R4: `data_off` depends on `mode` and the depth code. When `mode` is 2 it is 0. For any other mode it is 0x200 when the code is 3 to 7, and 0x20 otherwise. `frame_base` is the current buffer's top address plus `data_off`.
- R5: Let the buffer size be bottom minus top, taken as a signed value. If `data_off + (width*height*bpp)/8` is greater than the buffer size plus 2, the tick sets `sync_err`, clears `active`, and produces no `done`, no `cond_set` and no `dma_irq`. A need exactly equal to size plus 2 still fits.
- R6: When a frame fits, `done` is high during the cycle after the tick edge. In that same cycle, `cond_set` has only bit N set, where N is the current frame index, and `dma_irq` pulses if `dma_ie[0]` is 1.
- R7: Every accepted enable starts at frame index 0. When `dual` is 1, the index alternates 0,1,0 on successive completed frames, and `frame_base` and the size check use buffer 1 when the index is 1. When `dual` is 0, the index stays 0.
- R8: On an enable request (`en_wr` with `en_val` 1, while `active` is 0), the block checks the address flags. `addr_ok` bit 0 is buffer-0 top, bit 1 is buffer-0 bottom, bit 2 is buffer-1 top and bit 3 is buffer-1 bottom; bits 2 and 3 count only when `dual` is 1. If any checked flag is 0, `cond_set` pulses 3'b100, `dma_irq` pulses if `dma_ie[1]` is 1, and `active` stays 0.
- R9: A tick has no effect while `mode` is 1, while `active` is 0, or in a cycle where `en_wr` is high.
- R10: When `sub_en` is 1, `sub_line` gives `first_line` if `sub_first` is 1, or `line_cnt` if `sub_first` is 0. In every other case `first_line` is 0 and `line_cnt` is `height_m1`+1.
- R11: An accepted enable pulses `pal_load` when `mode` is not 2.
- R12: An accepted enable or disable clears `sync_err`. A disable request (`en_wr` with `en_val` 0, while `active` is 1) clears `active`.
- R13: After reset, `active`, `sync_err`, `done`, `pal_load`, `dma_irq` and `cond_set` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_val | input | 1 | Value written to the enable bit |
| mode | input | 2 | Palette/data loading mode |
| tft | input | 1 | Panel type; selects 16-bit colour at 16 bpp |
| dual | input | 1 | Two frame buffers in alternation |
| dma_ie | input | 2 | DMA interrupt enables: bit 0 for frame done, bit 1 for address fault |
| width_m1 | input | LW | Pixels per line minus one |
| height_m1 | input | LW | Lines per frame minus one |
| sub_en | input | 1 | Enables the partial-panel setting |
| sub_first | input | 1 | Partial-panel value is the first line (1) or the line count (0) |
| sub_line | input | LW | Partial-panel line value |
| frame_tick | input | 1 | Frame-start tick |
| pal_word0 | input | 16 | First palette word of the current buffer |
| buf0_top | input | AW | Buffer 0 start address |
| buf0_bot | input | AW | Buffer 0 end address |
| buf1_top | input | AW | Buffer 1 start address |
| buf1_bot | input | AW | Buffer 1 end address |
| addr_ok | input | 4 | Address validity flags, as laid out in R8 |
| active | output | 1 | Controller running |
| sync_err | output | 1 | Sticky buffer-overrun flag |
| pal_load | output | 1 | Palette load request pulse |
| dma_irq | output | 1 | DMA interrupt pulse |
| cond_set | output | 3 | DMA condition bits to set, as a pulse |
| done | output | 1 | Descriptor valid pulse |
| bpp | output | 5 | Bits per pixel |
| fmt16 | output | 1 | 16-bit colour format |
| data_off | output | 10 | Byte offset of pixel data |
| first_line | output | LW | First line to draw |
| line_cnt | output | LW+1 | Number of lines to draw |
| frame_base | output | AW | Start address of the pixel data |
| frame_idx | output | 1 | Buffer index used by this frame |

## Verification
The assertions assume that the register file holds `mode`, `dual`, the geometry and the buffer addresses steady around each tick. They also assume that reset is held for at least one clock edge, so that the history-based properties never see pre-reset values. The stimulus changes its configuration only on falling edges, several cycles before the strobe that uses it. Each tick and each enable write is a single-cycle pulse, and the two are never raised together.

// File: rtl/lcdseq_pkg.sv
`timescale 1ns/1ps
// Shared constants and decode helpers for the frame sequencer.
// Assumes the depth code is the 3-bit field taken from palette word 0.
package lcdseq_pkg;

    localparam logic [1:0] MODE_NO_FRAMES  = 2'd1;
    localparam logic [1:0] MODE_DATA_ONLY  = 2'd2;

    localparam logic [9:0] OFF_SHORT_HDR   = 10'h020;
    localparam logic [9:0] OFF_LONG_HDR    = 10'h200;

    localparam logic [2:0] COND_ADDR_FAULT = 3'b100;

    // Map the depth code to bits per pixel; 0 means unsupported.
    function automatic logic [4:0] depth_bits(input logic [2:0] code);
        case (code)
            3'd0:    depth_bits = 5'd0;
            3'd1:    depth_bits = 5'd2;
            3'd2:    depth_bits = 5'd4;
            3'd3:    depth_bits = 5'd8;
            default: depth_bits = 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/lcdseq_decode.sv
`timescale 1ns/1ps
// Pixel descriptor decode: depth, colour format and data offset.
// Purely combinational; assumes mode and tft are stable register fields.
module lcdseq_decode
    import lcdseq_pkg::*;
(
    input  logic [2:0] code,
    input  logic [1:0] mode,
    input  logic       tft,
    output logic [4:0] bpp,
    output logic       fmt16,
    output logic [9:0] off,
    output logic       supported
);

    // Derive the frame layout from the depth code and the loading mode.
    always_comb begin
        bpp       = depth_bits(code);
        supported = (code != 3'd0);
        fmt16     = tft && (bpp == 5'd16);
        if (mode == MODE_DATA_ONLY)
            off = 10'd0;
        else if (code >= 3'd3)
            off = OFF_LONG_HDR;
        else
            off = OFF_SHORT_HDR;
    end

endmodule

// File: rtl/lcdseq_fit.sv
`timescale 1ns/1ps
// Buffer fit check: data offset plus picture bytes must not exceed size + 2.
// Size is bottom minus top, taken as signed so that an inverted buffer fails.
module lcdseq_fit #(
    parameter int AW = 32,
    parameter int LW = 10
) (
    input  logic [LW-1:0] width_m1,
    input  logic [LW-1:0] height_m1,
    input  logic [4:0]    bpp,
    input  logic [9:0]    off,
    input  logic [AW-1:0] top,
    input  logic [AW-1:0] bot,
    output logic          fits
);

    localparam int CW = LW + 1;
    localparam int PW = 2 * CW + 5;
    localparam int NW = ((AW > PW) ? AW : PW) + 2;

    logic [PW-1:0]        prod;
    logic signed [NW-1:0] need;
    logic signed [NW-1:0] room;

    // Compare the bytes needed against the buffer room in signed arithmetic.
    always_comb begin
        prod = PW'({1'b0, width_m1} + CW'(1)) * PW'({1'b0, height_m1} + CW'(1)) * PW'(bpp);
        need = $signed(NW'(off)) + $signed(NW'(prod >> 3));
        room = $signed(NW'(bot)) - $signed(NW'(top)) + $signed(NW'(2));
        fits = (need <= room);
    end

endmodule

// File: rtl/lcdseq_frame.sv
`timescale 1ns/1ps
// Frame descriptor check and sequencer (top).
// Handles enable/disable requests and per-frame ticks, and emits a registered
// descriptor one cycle after each accepted tick. Assumes en_wr and frame_tick
// are single-cycle strobes; an enable write takes priority over a tick.
module lcdseq_frame
    import lcdseq_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_wr,
    input  logic          en_val,
    input  logic [1:0]    mode,
    input  logic          tft,
    input  logic          dual,
    input  logic [1:0]    dma_ie,
    input  logic [LW-1:0] width_m1,
    input  logic [LW-1:0] height_m1,
    input  logic          sub_en,
    input  logic          sub_first,
    input  logic [LW-1:0] sub_line,
    input  logic          frame_tick,
    input  logic [15:0]   pal_word0,
    input  logic [AW-1:0] buf0_top,
    input  logic [AW-1:0] buf0_bot,
    input  logic [AW-1:0] buf1_top,
    input  logic [AW-1:0] buf1_bot,
    input  logic [3:0]    addr_ok,
    output logic          active,
    output logic          sync_err,
    output logic          pal_load,
    output logic          dma_irq,
    output logic [2:0]    cond_set,
    output logic          done,
    output logic [4:0]    bpp,
    output logic          fmt16,
    output logic [9:0]    data_off,
    output logic [LW-1:0] first_line,
    output logic [LW:0]   line_cnt,
    output logic [AW-1:0] frame_base,
    output logic          frame_idx
);

    localparam int NBUF = 2;

    logic          idx;
    logic [4:0]    d_bpp;
    logic          d_fmt16;
    logic [9:0]    d_off;
    logic          d_supported;
    logic          d_fits;
    logic [AW-1:0] cur_top;
    logic [AW-1:0] cur_bot;
    logic [LW-1:0] nx_first;
    logic [LW:0]   nx_count;
    logic          addr_bad;
    logic          unused_pal;

    logic [AW-1:0] tops [NBUF];
    logic [AW-1:0] bots [NBUF];

    assign unused_pal = ^{pal_word0[15], pal_word0[11:0]};

    // Gather the two buffer descriptors into indexable arrays.
    assign tops[0] = buf0_top;
    assign tops[1] = buf1_top;
    assign bots[0] = buf0_bot;
    assign bots[1] = buf1_bot;

    // Select the current buffer's bounds from the frame index.
    always_comb begin
        cur_top = tops[idx];
        cur_bot = bots[idx];
    end

    lcdseq_decode u_decode (
        .code      (pal_word0[14:12]),
        .mode      (mode),
        .tft       (tft),
        .bpp       (d_bpp),
        .fmt16     (d_fmt16),
        .off       (d_off),
        .supported (d_supported)
    );

    lcdseq_fit #(.AW(AW), .LW(LW)) u_fit (
        .width_m1  (width_m1),
        .height_m1 (height_m1),
        .bpp       (d_bpp),
        .off       (d_off),
        .top       (cur_top),
        .bot       (cur_bot),
        .fits      (d_fits)
    );

    // Resolve the partial-panel setting into a first line and a line count.
    always_comb begin
        nx_first = '0;
        nx_count = {1'b0, height_m1} + (LW+1)'(1);
        if (sub_en) begin
            if (sub_first)
                nx_first = sub_line;
            else
                nx_count = {1'b0, sub_line};
        end
    end

    // Flag a bad address: buffer 0 is always checked, buffer 1 only in dual mode.
    always_comb begin
        addr_bad = !addr_ok[0] || !addr_ok[1] || (dual && (!addr_ok[2] || !addr_ok[3]));
    end

    // Sequencer state, strobes and the registered descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            sync_err   <= 1'b0;
            idx        <= 1'b0;
            pal_load   <= 1'b0;
            dma_irq    <= 1'b0;
            cond_set   <= 3'b000;
            done       <= 1'b0;
            bpp        <= 5'd0;
            fmt16      <= 1'b0;
            data_off   <= 10'd0;
            first_line <= '0;
            line_cnt   <= '0;
            frame_base <= '0;
            frame_idx  <= 1'b0;
        end else begin
            pal_load <= 1'b0;
            dma_irq  <= 1'b0;
            cond_set <= 3'b000;
            done     <= 1'b0;
            if (en_wr && en_val && !active) begin
                sync_err <= 1'b0;
                idx      <= 1'b0;
                if (addr_bad) begin
                    cond_set <= COND_ADDR_FAULT;
                    dma_irq  <= dma_ie[1];
                end else begin
                    active   <= 1'b1;
                    pal_load <= (mode != MODE_DATA_ONLY);
                end
            end else if (en_wr && !en_val && active) begin
                active   <= 1'b0;
                sync_err <= 1'b0;
                idx      <= 1'b0;
            end else if (!en_wr && frame_tick && active &&
                         mode != MODE_NO_FRAMES && d_supported) begin
                if (!d_fits) begin
                    sync_err <= 1'b1;
                    active   <= 1'b0;
                    idx      <= 1'b0;
                end else begin
                    done       <= 1'b1;
                    bpp        <= d_bpp;
                    fmt16      <= d_fmt16;
                    data_off   <= d_off;
                    first_line <= nx_first;
                    line_cnt   <= nx_count;
                    frame_base <= cur_top + AW'(d_off);
                    frame_idx  <= idx;
                    cond_set   <= 3'(1) << idx;
                    dma_irq    <= dma_ie[0];
                    if (dual)
                        idx <= ~idx;
                end
            end
        end
    end

endmodule

// File: rtl/lcdseq_frame_chk.sv
`timescale 1ns/1ps
// Property checker for lcdseq_frame, attached by bind below.
// Assumes reset is held for at least one clock edge before release.
module lcdseq_frame_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_wr,
    input logic [1:0] mode,
    input logic       frame_tick,
    input logic [2:0] depth_code,
    input logic       active,
    input logic       sync_err,
    input logic       pal_load,
    input logic       dma_irq,
    input logic [2:0] cond_set,
    input logic       done,
    input logic [4:0] bpp,
    input logic       fmt16
);

    p_bpp_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bpp == 5'd2 || bpp == 5'd4 || bpp == 5'd8 || bpp == 5'd16));

    p_skip_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !en_wr && depth_code == 3'd0) |=> (!done && cond_set == 3'b000 && !dma_irq));

    p_fmt_only16_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && bpp != 5'd16) |-> !fmt16);

    p_overrun_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err) |-> (!active && !done));

    p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(frame_tick) && $past(active) && !$past(en_wr)));

    p_cond_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cond_set));

    p_irq_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_irq |-> (cond_set != 3'b000));

    p_mode_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mode) != 2'd1));

    p_pal_on_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pal_load |-> (active && !$past(active)));

endmodule

bind lcdseq_frame lcdseq_frame_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_wr      (en_wr),
    .mode       (mode),
    .frame_tick (frame_tick),
    .depth_code (pal_word0[14:12]),
    .active     (active),
    .sync_err   (sync_err),
    .pal_load   (pal_load),
    .dma_irq    (dma_irq),
    .cond_set   (cond_set),
    .done       (done),
    .bpp        (bpp),
    .fmt16      (fmt16)
);

// File: tb/lcdseq_frame_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table for decode and fit, then directed tests.
module lcdseq_frame_tb_top;

    localparam int AW = 32;
    localparam int LW = 10;

    typedef struct packed {
        logic [2:0]  code;
        logic [1:0]  mode;
        logic        tft;
        logic [9:0]  wm1;
        logic [9:0]  hm1;
        logic [31:0] size;
        logic [4:0]  e_bpp;
        logic [9:0]  e_off;
        logic        e_fmt;
        logic        e_ok;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [NVEC] = '{
        '{3'd1, 2'd0, 1'b0, 10'd7, 10'd3, 32'd64,         5'd2,  10'h020, 1'b0, 1'b1},
        '{3'd2, 2'd0, 1'b0, 10'd7, 10'd3, 32'd64,         5'd4,  10'h020, 1'b0, 1'b1},
        '{3'd3, 2'd0, 1'b0, 10'd7, 10'd3, 32'h240,        5'd8,  10'h200, 1'b0, 1'b1},
        '{3'd4, 2'd0, 1'b0, 10'd7, 10'd3, 32'd574,        5'd16, 10'h200, 1'b0, 1'b1},
        '{3'd7, 2'd0, 1'b1, 10'd7, 10'd3, 32'd573,        5'd16, 10'h200, 1'b1, 1'b0},
        '{3'd5, 2'd2, 1'b1, 10'd7, 10'd3, 32'd64,         5'd16, 10'h000, 1'b1, 1'b1},
        '{3'd1, 2'd2, 1'b0, 10'd7, 10'd3, 32'd6,          5'd2,  10'h000, 1'b0, 1'b1},
        '{3'd6, 2'd3, 1'b1, 10'd7, 10'd3, 32'h300,        5'd16, 10'h200, 1'b1, 1'b1},
        '{3'd1, 2'd0, 1'b0, 10'd7, 10'd3, 32'hFFFF_FFFC,  5'd2,  10'h020, 1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_wr = 1'b0;
    logic          en_val = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          tft = 1'b0;
    logic          dual = 1'b0;
    logic [1:0]    dma_ie = 2'b01;
    logic [LW-1:0] width_m1 = 10'd7;
    logic [LW-1:0] height_m1 = 10'd3;
    logic          sub_en = 1'b0;
    logic          sub_first = 1'b0;
    logic [LW-1:0] sub_line = 10'd0;
    logic          frame_tick = 1'b0;
    logic [15:0]   pal_word0 = 16'h1000;
    logic [AW-1:0] buf0_top = 32'h0000_1000;
    logic [AW-1:0] buf0_bot = 32'h0000_2000;
    logic [AW-1:0] buf1_top = 32'h0000_8000;
    logic [AW-1:0] buf1_bot = 32'h0000_9000;
    logic [3:0]    addr_ok = 4'hF;
    logic          active, sync_err, pal_load, dma_irq, done, fmt16, frame_idx;
    logic [2:0]    cond_set;
    logic [4:0]    bpp;
    logic [9:0]    data_off;
    logic [LW-1:0] first_line;
    logic [LW:0]   line_cnt;
    logic [AW-1:0] frame_base;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    lcdseq_frame #(.AW(AW), .LW(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_val(en_val), .mode(mode),
        .tft(tft), .dual(dual), .dma_ie(dma_ie), .width_m1(width_m1),
        .height_m1(height_m1), .sub_en(sub_en), .sub_first(sub_first),
        .sub_line(sub_line), .frame_tick(frame_tick), .pal_word0(pal_word0),
        .buf0_top(buf0_top), .buf0_bot(buf0_bot), .buf1_top(buf1_top),
        .buf1_bot(buf1_bot), .addr_ok(addr_ok), .active(active),
        .sync_err(sync_err), .pal_load(pal_load), .dma_irq(dma_irq),
        .cond_set(cond_set), .done(done), .bpp(bpp), .fmt16(fmt16),
        .data_off(data_off), .first_line(first_line), .line_cnt(line_cnt),
        .frame_base(frame_base), .frame_idx(frame_idx)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // One-cycle enable write; outputs are sampled on the following falling edge.
    task automatic write_en(input logic v);
        @(negedge clk); en_wr = 1'b1; en_val = v;
        @(negedge clk); en_wr = 1'b0;
    endtask

    task automatic restart;
        write_en(1'b0);
        write_en(1'b1);
    endtask

    task automatic tick;
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL WDOG run hung act=running exp=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13 active", 32'(active), 0);
        check("R13 sync_err", 32'(sync_err), 0);
        check("R13 done", 32'(done), 0);
        check("R13 pal_load", 32'(pal_load), 0);
        check("R13 dma_irq", 32'(dma_irq), 0);
        check("R13 cond_set", 32'(cond_set), 0);
        rst_n = 1'b1;

        // Vector table: R1 depth, R3 format, R4 offset, R5 fit, R6 success strobes
        for (int i = 0; i < NVEC; i++) begin
            pal_word0 = {1'b0, VEC[i].code, 12'h000};
            mode      = VEC[i].mode;
            tft       = VEC[i].tft;
            width_m1  = VEC[i].wm1;
            height_m1 = VEC[i].hm1;
            buf0_bot  = buf0_top + VEC[i].size;
            restart();
            tick();
            check("R6 done", 32'(done), 32'(VEC[i].e_ok));
            if (VEC[i].e_ok) begin
                check("R1 bpp", 32'(bpp), 32'(VEC[i].e_bpp));
                check("R4 data_off", 32'(data_off), 32'(VEC[i].e_off));
                check("R3 fmt16", 32'(fmt16), 32'(VEC[i].e_fmt));
                check("R4 frame_base", frame_base, buf0_top + 32'(VEC[i].e_off));
                check("R6 cond_set", 32'(cond_set), 32'b001);
                check("R6 dma_irq", 32'(dma_irq), 1);
            end else begin
                check("R5 sync_err", 32'(sync_err), 1);
                check("R5 active", 32'(active), 0);
                check("R5 cond_set", 32'(cond_set), 0);
                check("R5 dma_irq", 32'(dma_irq), 0);
            end
        end

        // R12: the last vector overran; a new enable clears sync_err
        buf0_bot = 32'h0000_2000;
        mode = 2'd0;
        write_en(1'b1);
        check("R12 sync_err cleared", 32'(sync_err), 0);
        check("R12 active", 32'(active), 1);

        // R2: depth code 0 skips the frame
        pal_word0 = 16'h0000;
        tick();
        check("R2 done", 32'(done), 0);
        check("R2 cond_set", 32'(cond_set), 0);
        check("R2 dma_irq", 32'(dma_irq), 0);
        check("R2 active", 32'(active), 1);
        check("R2 sync_err", 32'(sync_err), 0);

        // R7: dual alternation 0,1,0 with per-buffer base
        pal_word0 = 16'h3000;
        dual = 1'b1;
        restart();
        tick();
        check("R7 idx0", 32'(frame_idx), 0);
        check("R7 cond0", 32'(cond_set), 32'b001);
        check("R7 base0", frame_base, 32'h0000_1200);
        tick();
        check("R7 idx1", 32'(frame_idx), 1);
        check("R7 cond1", 32'(cond_set), 32'b010);
        check("R7 base1", frame_base, 32'h0000_8200);
        tick();
        check("R7 idx back", 32'(frame_idx), 0);
        dual = 1'b0;
        restart();
        tick();
        tick();
        check("R7 single idx", 32'(frame_idx), 0);
        check("R7 single base", frame_base, 32'h0000_1200);

        // R10: partial panel
        sub_en = 1'b1; sub_first = 1'b1; sub_line = 10'd5;
        tick();
        check("R10 first", 32'(first_line), 5);
        check("R10 count full", 32'(line_cnt), 4);
        sub_first = 1'b0;
        tick();
        check("R10 first zero", 32'(first_line), 0);
        check("R10 count sub", 32'(line_cnt), 5);
        sub_en = 1'b0;
        tick();
        check("R10 count off", 32'(line_cnt), 4);

        // R9: mode 1 ignores ticks; R12 disable; ticks while inactive ignored
        mode = 2'd1;
        tick();
        check("R9 mode1 done", 32'(done), 0);
        check("R9 mode1 cond", 32'(cond_set), 0);
        mode = 2'd0;
        write_en(1'b0);
        check("R12 disabled", 32'(active), 0);
        tick();
        check("R9 inactive done", 32'(done), 0);

        // R11: palette load on enable unless mode 2
        write_en(1'b1);
        check("R11 pal_load mode0", 32'(pal_load), 1);
        mode = 2'd2;
        restart();
        check("R11 pal_load mode2", 32'(pal_load), 0);
        mode = 2'd0;

        // R8: address faults
        dma_ie = 2'b10;
        write_en(1'b0);
        addr_ok = 4'b1101;
        write_en(1'b1);
        check("R8 cond fault", 32'(cond_set), 32'b100);
        check("R8 irq fault", 32'(dma_irq), 1);
        check("R8 inactive", 32'(active), 0);
        addr_ok = 4'b0111;
        dual = 1'b1;
        write_en(1'b1);
        check("R8 dual fault", 32'(cond_set), 32'b100);
        check("R8 dual inactive", 32'(active), 0);
        dual = 1'b0;
        write_en(1'b1);
        check("R8 single ok", 32'(active), 1);
        check("R8 no fault", 32'(cond_set), 0);
        tick();
        check("R6 irq masked", 32'(dma_irq), 0);
        check("R6 done masked irq", 32'(done), 1);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule